// File: doc/BRIEF.md
# Reset Button Pulse Generator

This block watches an active-low reset push-button and turns a press into exactly one reset request of fixed length. When the debounce option is off, the falling edge of the button is enough. When it is on, the button must stay low through a set number of millisecond ticks first. A press counts only while the power-ok flag is high.

The request lasts between `PULSE_TICKS` and `PULSE_TICKS+1` tick periods, however long the button is held. Five periods of a 1 ms tick give the intended 5 to 6 ms window. A select bit, sampled when the press is accepted, decides whether the request goes out as a host reset (no power cycle) or as a full power-cycle request.

After a request the block will not start another until three things hold together: the button has been seen released (for the debounce interval when debounce is on), the system reports that it is fully running, and the platform reset reports inactive. All inputs are expected to be synchronous to `clk`. `msTick` is a one-cycle strobe.

Top module: `resetButtonPulser`

## Requirements
- R1: After reset, `hostRst` and `pwrCycleReq` are both low.
- R2: With `dbEn`=0 and `pwrOk`=1, a falling edge on `btnN` (1 then 0 on consecutive clocks) raises the selected output within 2 clock cycles.
- R3: With `dbEn`=1, the output rises only after `btnN` has stayed low through `DEBOUNCE_TICKS` tick strobes. A press released earlier produces no output.
- R4: Once raised, the output stays high for at least `PULSE_TICKS` and at most `PULSE_TICKS+1` tick periods, whether or not the button is still held.
- R5: After a request, no further press produces an output while `sysRunning`=0 or `pltRstInactive`=0, or while the button has not been released. A press seen during that time is not remembered.
- R6: Re-arming needs `btnN`=1 (for `DEBOUNCE_TICKS` ticks when `dbEn`=1), `sysRunning`=1 and `pltRstInactive`=1 together. After that a new press is accepted.
- R7: While `pwrOk`=0 a press produces no output.
- R8: `pwrCycleSel`=1 when the press is accepted drives `pwrCycleReq` instead of `hostRst`. The choice is held for the whole pulse, and the two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| btnN | input | 1 | Reset button, low when pressed |
| dbEn | input | 1 | 1 = debounce the button over DEBOUNCE_TICKS ticks |
| msTick | input | 1 | One-cycle millisecond strobe |
| sysRunning | input | 1 | System is back in the full running state |
| pltRstInactive | input | 1 | Platform reset is deasserted |
| pwrOk | input | 1 | Power good; presses count only while high |
| pwrCycleSel | input | 1 | 1 = request a full power cycle instead of a host reset |
| hostRst | output | 1 | Host reset request pulse |
| pwrCycleReq | output | 1 | Full power-cycle request pulse |

## Verification
The bench builds the block with `DEBOUNCE_TICKS`=4 and `PULSE_TICKS`=3 and drives a tick every 8 clocks. This keeps every window within a few dozen cycles. Both ends of the pulse-width range and the debounce latency bounds can then be measured exactly in clocks. Short presses, presses held past the pulse, and presses during each missing re-arm condition can all be tried in one short run.

// File: rtl/rbpPkg.sv
package rbpPkg;
  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_DEBOUNCE   = 2'd1,
    ST_ASSERT     = 2'd2,
    ST_WAIT_REARM = 2'd3
  } rbpState_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic modeLoad;
  } rbpStrobe_s;
endpackage

// File: rtl/rbpDatapath.sv
module rbpDatapath
  import rbpPkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             btnN,
  input  logic             msTick,
  input  logic             pwrCycleSel,
  input  rbpStrobe_s       strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic             btnFall,
  output logic             modeSel
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic btnPrev;

  // Tick counter shared by debounce, pulse width and release qualification
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strobe.cntClr) begin
      cntVal <= '0;
    end else if (strobe.cntInc && msTick && (cntVal != CNT_MAX)) begin
      cntVal <= cntVal + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) btnPrev <= 1'b1;
    else       btnPrev <= btnN;
  end

  assign btnFall = btnPrev && !btnN;

  // Action kind captured when the press is accepted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                modeSel <= 1'b0;
    else if (strobe.modeLoad) modeSel <= pwrCycleSel;
  end
endmodule

// File: rtl/rbpControl.sv
module rbpControl
  import rbpPkg::*;
#(
  parameter int DEBOUNCE_TICKS = 16,
  parameter int PULSE_TICKS    = 5,
  parameter int CNT_W          = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             btnN,
  input  logic             btnFall,
  input  logic             dbEn,
  input  logic             msTick,
  input  logic             pwrOk,
  input  logic             sysRunning,
  input  logic             pltRstInactive,
  input  logic             modeSel,
  input  logic [CNT_W-1:0] cntVal,
  output rbpStrobe_s       strobe,
  output logic             hostRst,
  output logic             pwrCycleReq
);
  localparam logic [CNT_W-1:0] DB_LIM    = CNT_W'(DEBOUNCE_TICKS);
  localparam logic [CNT_W-1:0] PULSE_LIM = CNT_W'(PULSE_TICKS + 1);

  rbpState_e state, stateNext;
  logic      releaseOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign releaseOk = dbEn ? (btnN && (cntVal >= DB_LIM)) : btnN;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (pwrOk && !dbEn && btnFall) begin
          stateNext       = ST_ASSERT;
          strobe.cntClr   = 1'b1;
          strobe.modeLoad = 1'b1;
        end else if (pwrOk && dbEn && !btnN) begin
          stateNext     = ST_DEBOUNCE;
          strobe.cntClr = 1'b1;
        end
      end
      ST_DEBOUNCE: begin
        strobe.cntInc = 1'b1;
        if (btnN || !pwrOk) begin
          stateNext = ST_IDLE;
        end else if (cntVal >= DB_LIM) begin
          stateNext       = ST_ASSERT;
          strobe.cntClr   = 1'b1;
          strobe.cntInc   = 1'b0;
          strobe.modeLoad = 1'b1;
        end
      end
      ST_ASSERT: begin
        strobe.cntInc = 1'b1;
        if (cntVal >= PULSE_LIM) begin
          stateNext     = ST_WAIT_REARM;
          strobe.cntClr = 1'b1;
          strobe.cntInc = 1'b0;
        end
      end
      ST_WAIT_REARM: begin
        if (!btnN) strobe.cntClr = 1'b1;
        else       strobe.cntInc = 1'b1;
        if (releaseOk && sysRunning && pltRstInactive) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign hostRst     = (state == ST_ASSERT) && !modeSel;
  assign pwrCycleReq = (state == ST_ASSERT) &&  modeSel;

  // Independent tick count over each pulse, for the width checks
  logic       anyOut;
  logic [7:0] pulseTickCnt;
  assign anyOut = hostRst || pwrCycleReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pulseTickCnt <= '0;
    else if (!anyOut)          pulseTickCnt <= '0;
    else if (msTick && pulseTickCnt != 8'hFF) pulseTickCnt <= pulseTickCnt + 1'b1;
  end

  p_exclusive_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(hostRst && pwrCycleReq));

  p_mode_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (anyOut && $past(anyOut)) |-> $stable(pwrCycleReq));

  p_start_pwrok_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyOut) |-> $past(pwrOk));

  p_min_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyOut) |-> ($past(pulseTickCnt) >= 8'(PULSE_TICKS)));

  p_max_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    anyOut |-> (pulseTickCnt <= 8'(PULSE_TICKS + 1)));

  p_rearm_cond_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state == ST_WAIT_REARM) && (state == ST_IDLE))
      |-> $past(sysRunning && pltRstInactive && btnN));
endmodule

// File: rtl/resetButtonPulser.sv
module resetButtonPulser
  import rbpPkg::*;
#(
  parameter int DEBOUNCE_TICKS = 16,
  parameter int PULSE_TICKS    = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic btnN,
  input  logic dbEn,
  input  logic msTick,
  input  logic sysRunning,
  input  logic pltRstInactive,
  input  logic pwrOk,
  input  logic pwrCycleSel,
  output logic hostRst,
  output logic pwrCycleReq
);
  localparam int MAX_COUNT = (DEBOUNCE_TICKS > PULSE_TICKS + 1) ? DEBOUNCE_TICKS : PULSE_TICKS + 1;
  localparam int CNT_W     = $clog2(MAX_COUNT + 2);

  rbpStrobe_s       strobe;
  logic [CNT_W-1:0] cntVal;
  logic             btnFall;
  logic             modeSel;

  rbpDatapath #(.CNT_W(CNT_W)) datapath_i (
    .clk(clk), .rstN(rstN), .btnN(btnN), .msTick(msTick),
    .pwrCycleSel(pwrCycleSel), .strobe(strobe),
    .cntVal(cntVal), .btnFall(btnFall), .modeSel(modeSel)
  );

  rbpControl #(
    .DEBOUNCE_TICKS(DEBOUNCE_TICKS), .PULSE_TICKS(PULSE_TICKS), .CNT_W(CNT_W)
  ) control_i (
    .clk(clk), .rstN(rstN), .btnN(btnN), .btnFall(btnFall), .dbEn(dbEn),
    .msTick(msTick), .pwrOk(pwrOk), .sysRunning(sysRunning),
    .pltRstInactive(pltRstInactive), .modeSel(modeSel), .cntVal(cntVal),
    .strobe(strobe), .hostRst(hostRst), .pwrCycleReq(pwrCycleReq)
  );
endmodule

// File: tb/resetButtonPulser_tb_top.sv
module resetButtonPulser_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DB   = 4;
  localparam int PT   = 3;
  localparam int DIV  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic btnN = 1'b1, dbEn = 1'b0, msTick = 1'b0;
  logic sysRunning = 1'b1, pltRstInactive = 1'b1, pwrOk = 1'b1, pwrCycleSel = 1'b0;
  logic hostRst, pwrCycleReq;

  int checkCnt = 0;
  int failCnt  = 0;
  int tickDiv  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tickDiv <= (tickDiv == DIV-1) ? 0 : tickDiv + 1;
    msTick  <= (tickDiv == DIV-1);
  end

  resetButtonPulser #(.DEBOUNCE_TICKS(DB), .PULSE_TICKS(PT)) dut_i (
    .clk(clk), .rstN(rstN), .btnN(btnN), .dbEn(dbEn), .msTick(msTick),
    .sysRunning(sysRunning), .pltRstInactive(pltRstInactive), .pwrOk(pwrOk),
    .pwrCycleSel(pwrCycleSel), .hostRst(hostRst), .pwrCycleReq(pwrCycleReq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Wait up to maxWait cycles for any output; report latency, width, kind
  task automatic watchPulse(input int maxWait, output int lat, output int width,
                            output bit sawHost, output bit sawPc);
    lat = -1; width = 0; sawHost = 0; sawPc = 0;
    for (int i = 1; i <= maxWait; i++) begin
      @(negedge clk);
      if (hostRst || pwrCycleReq) begin lat = i; break; end
    end
    if (lat < 0) return;
    while (hostRst || pwrCycleReq) begin
      sawHost |= hostRst;
      sawPc   |= pwrCycleReq;
      width++;
      if (width > 200) break;
      @(negedge clk);
    end
  endtask

  task automatic rearm();
    btnN = 1'b1; sysRunning = 1'b1; pltRstInactive = 1'b1;
    cyc((DB + 2) * DIV);
  endtask

  task automatic t_reset_state();
    check(!hostRst && !pwrCycleReq, "R1", "outputs after reset",
          int'(hostRst) + int'(pwrCycleReq), 0);
  endtask

  task automatic t_edge_press();
    int lat, w; bit h, p;
    dbEn = 1'b0; pwrCycleSel = 1'b0;
    @(negedge clk); btnN = 1'b0;
    cyc(1);
    btnN = 1'b1;   // released early: width must not shrink
    watchPulse(4, lat, w, h, p);
    check(lat >= 0 && lat <= 2, "R2", "edge latency", lat + 1, 1);
    check(h && !p, "R2", "host output chosen", int'(h), 1);
    check(w >= PT*DIV && w <= (PT+1)*DIV + 1, "R4", "width on short press", w, PT*DIV);
    rearm();
  endtask

  task automatic t_long_hold();
    int lat, w; bit h, p;
    dbEn = 1'b0;
    @(negedge clk); btnN = 1'b0;
    watchPulse(4, lat, w, h, p);
    check(w >= PT*DIV && w <= (PT+1)*DIV + 1, "R4", "width while held", w, PT*DIV);
    cyc(3 * DIV);
    check(!hostRst && !pwrCycleReq, "R5", "no retrigger while held", int'(hostRst), 0);
    rearm();
  endtask

  task automatic t_rearm_gates();
    int lat, w; bit h, p;
    dbEn = 1'b0;
    @(negedge clk); btnN = 1'b0;
    watchPulse(4, lat, w, h, p);
    sysRunning = 1'b0;
    btnN = 1'b1; cyc(4);
    btnN = 1'b0;
    watchPulse(3 * DIV, lat, w, h, p);
    check(lat < 0, "R5", "press ignored while not running", lat, -1);
    sysRunning = 1'b1; pltRstInactive = 1'b0;
    btnN = 1'b1; cyc(4);
    btnN = 1'b0;
    watchPulse(3 * DIV, lat, w, h, p);
    check(lat < 0, "R5", "press ignored under platform reset", lat, -1);
    pltRstInactive = 1'b1;
    watchPulse(3 * DIV, lat, w, h, p);
    check(lat < 0, "R5", "held press not remembered", lat, -1);
    btnN = 1'b1; cyc(3);
    btnN = 1'b0;
    watchPulse(4, lat, w, h, p);
    check(lat >= 0, "R6", "press accepted after re-arm", lat, 1);
    rearm();
  endtask

  task automatic t_debounce();
    int lat, w; bit h, p;
    dbEn = 1'b1;
    @(negedge clk); btnN = 1'b0;
    watchPulse((DB + 2) * DIV, lat, w, h, p);
    check(lat >= (DB-1)*DIV + 1 && lat <= DB*DIV + 3, "R3", "debounce latency", lat, DB*DIV);
    check(w >= PT*DIV && w <= (PT+1)*DIV + 1, "R4", "width after debounce", w, PT*DIV);
    // release shorter than the debounce window must not re-arm
    btnN = 1'b1; cyc(DIV);
    btnN = 1'b0;
    watchPulse((DB + 2) * DIV, lat, w, h, p);
    check(lat < 0, "R6", "short release does not re-arm", lat, -1);
    rearm();
    btnN = 1'b0;
    watchPulse((DB + 2) * DIV, lat, w, h, p);
    check(lat >= 0, "R6", "debounced release re-arms", lat, DB*DIV);
    rearm();
  endtask

  task automatic t_glitch();
    int lat, w; bit h, p;
    dbEn = 1'b1;
    @(negedge clk); btnN = 1'b0;
    cyc((DB - 2) * DIV);
    btnN = 1'b1;
    watchPulse((DB + 2) * DIV, lat, w, h, p);
    check(lat < 0, "R3", "short press filtered", lat, -1);
  endtask

  task automatic t_pwrok();
    int lat, w; bit h, p;
    pwrOk = 1'b0;
    dbEn = 1'b0;
    @(negedge clk); btnN = 1'b0;
    watchPulse(3 * DIV, lat, w, h, p);
    check(lat < 0, "R7", "edge press without power ok", lat, -1);
    btnN = 1'b1; cyc(2);
    dbEn = 1'b1; btnN = 1'b0;
    watchPulse((DB + 2) * DIV, lat, w, h, p);
    check(lat < 0, "R7", "debounced press without power ok", lat, -1);
    btnN = 1'b1; pwrOk = 1'b1; cyc(2);
  endtask

  task automatic t_power_cycle();
    int lat, w; bit h, p;
    dbEn = 1'b0; pwrCycleSel = 1'b1;
    @(negedge clk); btnN = 1'b0;
    cyc(1);
    pwrCycleSel = 1'b0;   // change after acceptance must not switch kind
    watchPulse(4, lat, w, h, p);
    check(p && !h, "R8", "power-cycle output only", int'(p) * 2 + int'(h), 2);
    check(w >= PT*DIV && w <= (PT+1)*DIV + 1, "R4", "power-cycle width", w, PT*DIV);
    rearm();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    cyc(3);
    t_reset_state();
    rstN = 1'b1;
    cyc(3);
    t_reset_state();
    t_edge_press();
    t_long_hold();
    t_rearm_gates();
    t_debounce();
    t_glitch();
    t_pwrok();
    t_power_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule